// File: doc/BRIEF.md
# Shaped Envelope Generator

This block produces one 4-bit amplitude level that a sound generator shares across its channels. A fixed prescaler divides the clock by 16. A programmable 16-bit period then divides the result again, and each resulting tick moves the envelope by one step. Sixteen steps make one envelope cycle. A whole cycle therefore lasts 256·P clocks, and each step lasts 16·P clocks.

A 4-bit shape code sets the pattern. Its fields are b3 continue, b2 attack, b1 alternate and b0 hold. From these the block makes one-shot decays and rises, repeating sawtooth ramps, triangles, and patterns that end parked at the top or at the bottom. Writing a new shape code restarts the envelope from its first step. The period is a live input and can be changed at any time. The shape code is captured on a write strobe.

Top module: `env_shaper`

## Requirements
- R1: After reset the level is 0 and stays at 0, whatever the period, until the first shape write.
- R2: After a shape write, the level changes only at step ticks. The first tick comes 16·P clocks after the clock edge that captured the write, and later ticks follow every 16·P clocks. P is `period_i`, with the coarse byte in bits 15:8 and the fine byte in bits 7:0.
- R3: A period of 0 gives exactly the same timing as a period of 1.
- R4: During the first cycle after a write, step k (0..15) shows level k when attack (b2) is 1, and level 15−k when attack is 0.
- R5: When continue (b3) is 0, the level goes to 0 at the end of the first cycle and stays there.
- R6: When continue is 1 and hold (b0) is 0, the cycles repeat. If alternate (b1) is 1, the direction reverses at the start of every cycle. If alternate is 0, the direction never changes.
- R7: When continue is 1 and hold is 1, the level is parked after the first cycle. It parks at 15 if attack XOR alternate is 1, and at 0 otherwise.
- R8: A shape write restarts the envelope at step 0 of the new code and clears any parked state. If the write falls in the same clock as a step tick, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 16 | Step period P (coarse byte high, fine byte low) |
| shape_i | input | 4 | Shape code {continue, attack, alternate, hold} |
| shape_wr_i | input | 1 | Strobe that captures `shape_i` and restarts the envelope |
| level_o | output | 4 | Envelope level |

## Verification
A shape write and a step tick can land on the same clock edge. The bench forces this collision: it lets an envelope run to the edge just before a step boundary, then drives the write so that it is sampled on the tick edge itself. The level right after that edge must be step 0 of the new code, not the next step of the old code. The following steps must then keep the 16·P spacing measured from the write.

// File: rtl/env_pkg.sv
package env_pkg;
   // decoded shape code fields
   typedef struct packed {
      logic cont;
      logic attack;
      logic alt;
      logic hold;
   } env_shape_t;
endpackage

// File: rtl/env_prescale.sv
module env_prescale #(
   parameter int PRE_DIV = 16,
   localparam int CW     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   logic [CW-1:0] cnt_q;

   if (PRE_DIV < 2) begin : g_bad_div
      $error("env_prescale: PRE_DIV must be at least 2");
   end

   if ((1 << CW) == PRE_DIV) begin : g_pow2
      // power-of-two divider: free wrap, all-ones marks the tick
      assign tick_o = &cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) cnt_q <= '0;
         else                 cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      assign tick_o = (cnt_q == CW'(PRE_DIV - 1));
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) cnt_q <= '0;
         else if (tick_o)     cnt_q <= '0;
         else                 cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: prescaler restarts from zero after each tick
   p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/env_period_div.sv
module env_period_div #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             pre_tick_i,
   input  logic [PER_W-1:0] period_i,
   output logic             step_o
);
   logic [PER_W-1:0] div_q;
   logic [PER_W-1:0] per_eff;

   if (PER_W < 2) begin : g_bad_w
      $error("env_period_div: PER_W must be at least 2");
   end

   // zero period is treated as one
   assign per_eff = (period_i == '0) ? PER_W'(1) : period_i;
   // >= keeps the divider bounded when the period shrinks mid-count
   assign step_o  = pre_tick_i && (div_q >= per_eff - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)  div_q <= '0;
      else if (pre_tick_i)  div_q <= step_o ? '0 : div_q + 1'b1;
   end

   // R3: with period 0 or 1 every prescaler tick is a step
   p_min_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_tick_i && period_i <= PER_W'(1)) |-> step_o);
   // R2: step only ever on a prescaler tick
   p_step_on_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> pre_tick_i);
endmodule

// File: rtl/env_step_seq.sv
module env_step_seq
   import env_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [3:0]       shape_i,
   input  logic             step_i,
   output logic [LVL_W-1:0] level_o
);
   localparam logic [LVL_W-1:0] TOP = '1;

   env_shape_t       shp_q;
   logic [LVL_W-1:0] cnt_q;
   logic [LVL_W-1:0] park_q;
   logic             flip_q;
   logic             parked_q;

   if (LVL_W < 2) begin : g_bad_lvl
      $error("env_step_seq: LVL_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shp_q    <= '0;
         cnt_q    <= '0;
         flip_q   <= 1'b0;
         parked_q <= 1'b1;
         park_q   <= '0;
      end else if (wr_i) begin
         shp_q    <= env_shape_t'(shape_i);
         cnt_q    <= '0;
         flip_q   <= 1'b0;
         parked_q <= 1'b0;
      end else if (step_i && !parked_q) begin
         if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (!shp_q.cont) begin
            parked_q <= 1'b1;
            park_q   <= '0;
         end else if (shp_q.hold) begin
            parked_q <= 1'b1;
            park_q   <= (shp_q.attack ^ shp_q.alt) ? TOP : '0;
         end else begin
            cnt_q  <= '0;
            flip_q <= flip_q ^ shp_q.alt;
         end
      end
   end

   always_comb begin
      if (parked_q)                   level_o = park_q;
      else if (shp_q.attack ^ flip_q) level_o = cnt_q;
      else                            level_o = ~cnt_q;
   end

   // R8: a write always restarts at step 0 and leaves the parked state
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (cnt_q == '0 && !parked_q && !flip_q));
   // R5: once parked, only a write releases the level
   p_park_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (parked_q && !wr_i) |=> (parked_q && $stable(level_o)));
   // R1: before any write the level is parked at zero
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (shp_q == '0 && parked_q) |-> (level_o == '0));
endmodule

// File: rtl/env_shaper.sv
module env_shaper #(
   parameter int PRE_DIV = 16,
   parameter int PER_W   = 16,
   parameter int LVL_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period_i,
   input  logic [3:0]       shape_i,
   input  logic             shape_wr_i,
   output logic [LVL_W-1:0] level_o
);
   logic pre_tick;
   logic step_tick;

   env_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (shape_wr_i),
      .tick_o (pre_tick)
   );

   env_period_div #(.PER_W(PER_W)) i_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (shape_wr_i),
      .pre_tick_i (pre_tick),
      .period_i   (period_i),
      .step_o     (step_tick)
   );

   env_step_seq #(.LVL_W(LVL_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (shape_wr_i),
      .shape_i (shape_i),
      .step_i  (step_tick),
      .level_o (level_o)
   );

   // R2: the level moves only on a step tick or a write
   p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_tick && !shape_wr_i) |=> $stable(level_o));
endmodule

// File: tb/test_env_shaper.sv
module test_env_shaper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] period_i = 16'd1;
   logic [3:0]  shape_i = 4'd0;
   logic        shape_wr_i = 1'b0;
   logic [3:0]  level_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [3:0] cur_shape;
   int         cur_pe;
   int         n;

   always #2.5 clk = ~clk;

   env_shaper i_env_shaper (
      .clk(clk), .rst_n(rst_n), .period_i(period_i),
      .shape_i(shape_i), .shape_wr_i(shape_wr_i), .level_o(level_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 199000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // expected level at step index idx for a shape code
   function automatic logic [3:0] exp_level(logic [3:0] s, int idx);
      logic c, a, al, h, up;
      int cyc, st;
      c = s[3]; a = s[2]; al = s[1]; h = s[0];
      if (idx < 16) return a ? 4'(idx) : 4'(15 - idx);
      if (!c) return 4'd0;
      if (h)  return (a ^ al) ? 4'd15 : 4'd0;
      cyc = idx / 16;
      st  = idx % 16;
      up  = a ^ (al & cyc[0]);
      return up ? 4'(st) : 4'(15 - st);
   endfunction

   function automatic string tag_for(logic [3:0] s, int idx, int nn, int pe, int praw);
      if (idx == 0) return "R8";
      if (praw == 0) return "R3";
      if (idx < 16) return (nn % (16 * pe) == 0) ? "R2" : "R4";
      if (!s[3]) return "R5";
      if (s[0])  return "R7";
      return "R6";
   endfunction

   task automatic check(logic [3:0] exp, string tag);
      checks++;
      if (level_o !== exp) begin
         fails++;
         $display("FAIL %s shape=%b n=%0d level=%0d expected=%0d",
                  tag, cur_shape, n, level_o, exp);
      end
   endtask

   task automatic write_shape(logic [3:0] s, logic [15:0] p);
      @(negedge clk);
      shape_i    = s;
      period_i   = p;
      shape_wr_i = 1'b1;
      @(posedge clk);
      #1;
      shape_wr_i = 1'b0;
      cur_shape  = s;
      cur_pe     = (p == 0) ? 1 : int'(p);
      n          = 0;
      check(exp_level(s, 0), "R8");
   endtask

   task automatic run_edges(int count);
      for (int k = 0; k < count; k++) begin
         @(posedge clk);
         #1;
         n++;
         check(exp_level(cur_shape, n / (16 * cur_pe)),
               tag_for(cur_shape, n / (16 * cur_pe), n, cur_pe, int'(period_i)));
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      cur_shape = 4'd0;
      cur_pe = 1;
      n = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: zero level after reset, no write yet
      for (int k = 0; k < 40; k++) begin
         @(posedge clk);
         #1;
         check(4'd0, "R1");
      end

      // directed: every shape code over three cycles with period 1
      for (int s = 0; s < 16; s++) begin
         write_shape(4'(s), 16'd1);
         run_edges(16 * 48);
      end

      // R3: period 0 behaves as period 1
      write_shape(4'b1110, 16'd0);
      run_edges(16 * 40);

      // R8: write collides with a step tick
      write_shape(4'b1000, 16'd2);
      run_edges(16 * 2 * 2 - 1);
      write_shape(4'b1100, 16'd2);
      run_edges(16 * 2 * 20);

      // R8: write while parked releases the hold
      write_shape(4'b1011, 16'd1);
      run_edges(16 * 20);
      write_shape(4'b0100, 16'd1);
      run_edges(16 * 20);

      // random shapes and small periods
      for (int t = 0; t < 40; t++) begin
         logic [3:0]  rs;
         logic [15:0] rp;
         rs = 4'($urandom_range(0, 15));
         rp = 16'($urandom_range(0, 3));
         write_shape(rs, rp);
         run_edges(16 * ((rp == 0) ? 1 : int'(rp)) * 40);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule